// File: doc/BRIEF.md
# Bit Scan and Count Unit

This unit takes one 32-bit word and an 8-bit operation code. It returns one of five single-operand bit results: the word with its bit order reversed, the count of one bits, the position of the lowest one bit, the position of the highest one bit, or the position of the highest bit that differs from the sign bit. The three position operations return the all-ones word when there is nothing to find.

Operands arrive through a valid/ready handshake. Each accepted operation is computed combinationally and captured in one output register, which holds it until the consumer takes it. A code that matches none of the five operations produces a zero result, and an error flag travels with that result.

Top module: `bit_scan_unit`

## Requirements
- R1: Operation code 187 (reverse) returns a word whose bit 31-i equals operand bit i, for every i from 0 to 31.
- R2: Operation code 188 (count) returns the number of one bits in the operand, from 0 to 32, zero-extended to 32 bits.
- R3: Operation code 189 (lowest) returns the index of the least significant one bit, zero-extended, or 32'hFFFFFFFF when the operand is zero.
- R4: Operation code 191 (highest unsigned) returns the index of the most significant one bit, zero-extended, or 32'hFFFFFFFF when the operand is zero.
- R5: Operation code 190 (highest signed) returns the index of the highest zero bit when bit 31 is set, and of the highest one bit otherwise; for operands 0 and 32'hFFFFFFFF it returns 32'hFFFFFFFF.
- R6: Any other operation code returns a result of 0 with error_o high; the five codes above return error_o low.
- R7: An operation accepted on a clock edge (in_valid_i and in_ready_o both high) appears on result_o and error_o with out_valid_o high after that same edge.
- R8: in_ready_o is high whenever the output register is empty or out_ready_i is high; while out_valid_o is high and out_ready_i low, result_o, error_o and out_valid_o hold, and an offered operation is not taken.
- R9: While rst_ni is low, out_valid_o, result_o and error_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | An operation is offered |
| in_ready_o | output | 1 | The unit can take an operation this cycle |
| opcode_i | input | 8 | Operation code |
| operand_i | input | 32 | Operand word |
| out_valid_o | output | 1 | result_o and error_o carry a result |
| out_ready_i | input | 1 | The consumer takes the result this cycle |
| result_o | output | 32 | Result word |
| error_o | output | 1 | The result came from an unknown operation code |

## Verification
Each operation is tried with zero, all ones, single set bits at both ends and in the middle, and patterns with sparse ones or zeros near the top or bottom, so an off-by-one in an index, a scan from the wrong end or a missing sentinel shows as a different value. For the signed scan, negative words with one zero bit, and 0 and all ones, separate the inverted search from the plain one. Pseudo-random words across all five codes catch mixed-up operation decoding, and a stalled consumer with a second operation waiting shows whether the output holds and the waiting operation is taken only once the stall ends.

// File: rtl/bit_scan_pkg.sv
package bit_scan_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OPC_W  = 8;

  // Operation codes; values are fixed by the instruction encoding.
  localparam logic [OPC_W-1:0] OPC_REV  = 8'd187;
  localparam logic [OPC_W-1:0] OPC_POPC = 8'd188;
  localparam logic [OPC_W-1:0] OPC_LOW  = 8'd189;
  localparam logic [OPC_W-1:0] OPC_SHI  = 8'd190;
  localparam logic [OPC_W-1:0] OPC_UHI  = 8'd191;
endpackage

// File: rtl/bit_scan_reverse.sv
module bit_scan_reverse #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign data_o[W-1-i] = data_i[i];
  end
endmodule

// File: rtl/bit_scan_popcount.sv
module bit_scan_popcount #(
  parameter int unsigned W     = 32,
  localparam int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     data_i,
  output logic [CNT_W-1:0] count_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < W; i++) begin
      count_o = count_o + CNT_W'(data_i[i]);
    end
  end
endmodule

// File: rtl/bit_scan_find.sv
// Priority search for a one bit; HIGH_FIRST picks the end that wins.
module bit_scan_find #(
  parameter int unsigned W          = 32,
  parameter bit          HIGH_FIRST = 1'b1,
  localparam int unsigned IDX_W     = $clog2(W)
) (
  input  logic [W-1:0]     data_i,
  output logic             found_o,
  output logic [IDX_W-1:0] index_o
);
  assign found_o = |data_i;

  if (HIGH_FIRST) begin : g_high
    always_comb begin
      index_o = '0;
      for (int i = 0; i < W; i++) begin
        if (data_i[i]) index_o = IDX_W'(i);
      end
    end
  end else begin : g_low
    always_comb begin
      index_o = '0;
      for (int i = W - 1; i >= 0; i--) begin
        if (data_i[i]) index_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/bit_scan_unit.sv
module bit_scan_unit
  import bit_scan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] result_o,
  output logic              error_o
);
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] rev_w;
  logic [CNT_W-1:0]  cnt_w;
  logic              low_found, uhi_found, shi_found;
  logic [IDX_W-1:0]  low_idx, uhi_idx, shi_idx;
  logic [DATA_W-1:0] folded_w;

  // Signed scan: fold negatives so the search looks for the first non-sign bit.
  assign folded_w = operand_i ^ {DATA_W{operand_i[DATA_W-1]}};

  bit_scan_reverse #(.W(DATA_W)) u_rev (.data_i(operand_i), .data_o(rev_w));

  bit_scan_popcount #(.W(DATA_W)) u_cnt (.data_i(operand_i), .count_o(cnt_w));

  bit_scan_find #(.W(DATA_W), .HIGH_FIRST(1'b0)) u_low (
    .data_i(operand_i), .found_o(low_found), .index_o(low_idx)
  );

  bit_scan_find #(.W(DATA_W), .HIGH_FIRST(1'b1)) u_uhi (
    .data_i(operand_i), .found_o(uhi_found), .index_o(uhi_idx)
  );

  bit_scan_find #(.W(DATA_W), .HIGH_FIRST(1'b1)) u_shi (
    .data_i(folded_w), .found_o(shi_found), .index_o(shi_idx)
  );

  logic [DATA_W-1:0] res_d;
  logic              err_d;

  always_comb begin
    res_d = '0;
    err_d = 1'b0;
    unique case (opcode_i)
      OPC_REV:  res_d = rev_w;
      OPC_POPC: res_d = DATA_W'(cnt_w);
      OPC_LOW:  res_d = low_found ? DATA_W'(low_idx) : '1;
      OPC_UHI:  res_d = uhi_found ? DATA_W'(uhi_idx) : '1;
      OPC_SHI:  res_d = shi_found ? DATA_W'(shi_idx) : '1;
      default:  err_d = 1'b1;
    endcase
  end

  logic              vld_q;
  logic [DATA_W-1:0] res_q;
  logic              err_q;
  logic              take;

  assign in_ready_o = !vld_q || out_ready_i;
  assign take       = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
      err_q <= 1'b0;
    end else if (take) begin
      vld_q <= 1'b1;
      res_q <= res_d;
      err_q <= err_d;
    end else if (out_ready_i) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid_o = vld_q;
  assign result_o    = res_q;
  assign error_o     = err_q;
endmodule

// File: rtl/bit_scan_unit_chk.sv
module bit_scan_unit_chk
  import bit_scan_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [OPC_W-1:0]  opcode_i,
  input logic [DATA_W-1:0] operand_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] result_o,
  input logic              error_o
);
  logic acc;
  assign acc = in_valid_i && in_ready_o;

  a_r7_result_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> out_valid_o);

  a_r8_ready_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);

  a_r8_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(result_o) && $stable(error_o)));

  a_r6_error_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && error_o) |-> (result_o == '0));

  a_r2_count_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && opcode_i == OPC_POPC) |=> (result_o == DATA_W'($countones($past(operand_i)))));

  a_r3_low_zero_sentinel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && opcode_i == OPC_LOW && operand_i == '0) |=> (result_o == '1));

  a_r4_high_zero_sentinel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && opcode_i == OPC_UHI && operand_i == '0) |=> (result_o == '1));

  a_r5_signed_flat_sentinel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && opcode_i == OPC_SHI && (operand_i == '0 || operand_i == '1)) |=> (result_o == '1));

  always_comb begin
    if (!rst_ni) begin
      a_r9_reset_clear: assert (!out_valid_o && result_o == '0 && !error_o);
    end
  end
endmodule

bind bit_scan_unit bit_scan_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .opcode_i(opcode_i), .operand_i(operand_i), .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i), .result_o(result_o), .error_o(error_o)
);

// File: tb/bit_scan_unit_tb_top.sv
`timescale 1ns/1ps
module bit_scan_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [7:0]  opcode_i = '0;
  logic [31:0] operand_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [31:0] result_o;
  logic        error_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  bit_scan_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .opcode_i(opcode_i), .operand_i(operand_i), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .result_o(result_o), .error_o(error_o)
  );

  function automatic logic [31:0] model(input logic [7:0] op, input logic [31:0] x);
    logic [31:0] r;
    logic [31:0] y;
    r = '0;
    case (op)
      8'd187: for (int i = 0; i < 32; i++) r[31-i] = x[i];
      8'd188: for (int i = 0; i < 32; i++) r = r + {31'd0, x[i]};
      8'd189: begin
        r = '1;
        for (int i = 31; i >= 0; i--) if (x[i]) r = i;
      end
      8'd190, 8'd191: begin
        y = (op == 8'd190 && x[31]) ? ~x : x;
        r = '1;
        for (int i = 0; i < 32; i++) if (y[i]) r = i;
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One accepted operation; result sampled at the following negedge.
  task automatic run_op(input string req, input logic [7:0] op, input logic [31:0] x);
    @(negedge clk_i);
    out_ready_i = 1'b1;
    in_valid_i  = 1'b1;
    opcode_i    = op;
    operand_i   = x;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check({req, " valid"}, {31'd0, out_valid_o}, 32'd1);
    check(req, result_o, model(op, x));
    check({req, " err"}, {31'd0, error_o}, 32'd0);
  endtask

  task automatic t_reset;
    check("R9 valid", {31'd0, out_valid_o}, 32'd0);
    check("R9 result", result_o, 32'd0);
    check("R9 err", {31'd0, error_o}, 32'd0);
  endtask

  task automatic t_reverse;
    run_op("R1", 8'd187, 32'h0000_0001);
    run_op("R1", 8'd187, 32'h8000_0000);
    run_op("R1", 8'd187, 32'h1234_5678);
    run_op("R1", 8'd187, 32'hFFFF_0000);
  endtask

  task automatic t_count;
    run_op("R2", 8'd188, 32'h0000_0000);
    run_op("R2", 8'd188, 32'hFFFF_FFFF);
    run_op("R2", 8'd188, 32'h8000_0001);
    run_op("R2", 8'd188, 32'hF0F0_1234);
  endtask

  task automatic t_low;
    run_op("R3", 8'd189, 32'h0000_0000);
    run_op("R3", 8'd189, 32'h0000_0001);
    run_op("R3", 8'd189, 32'h8000_0000);
    run_op("R3", 8'd189, 32'hFFFF_0100);
    run_op("R3", 8'd189, 32'hFFFF_FFFF);
  endtask

  task automatic t_uhi;
    run_op("R4", 8'd191, 32'h0000_0000);
    run_op("R4", 8'd191, 32'h0000_0001);
    run_op("R4", 8'd191, 32'h8000_0000);
    run_op("R4", 8'd191, 32'h0001_FFFF);
    run_op("R4", 8'd191, 32'hFFFF_FFFF);
  endtask

  task automatic t_shi;
    run_op("R5", 8'd190, 32'h0000_0000);
    run_op("R5", 8'd190, 32'hFFFF_FFFF);
    run_op("R5", 8'd190, 32'h0000_0001);
    run_op("R5", 8'd190, 32'h7FFF_FFFF);
    run_op("R5", 8'd190, 32'h8000_0000);
    run_op("R5", 8'd190, 32'hFFFF_FFFE);
    run_op("R5", 8'd190, 32'hFFEF_FFFF);
  endtask

  task automatic t_bad_code;
    logic [7:0] codes [4] = '{8'd0, 8'd186, 8'd192, 8'd255};
    foreach (codes[k]) begin
      @(negedge clk_i);
      in_valid_i = 1'b1;
      opcode_i   = codes[k];
      operand_i  = 32'hDEAD_BEEF;
      @(negedge clk_i);
      in_valid_i = 1'b0;
      check("R6 result", result_o, 32'd0);
      check("R6 err", {31'd0, error_o}, 32'd1);
    end
  endtask

  task automatic t_timing;
    // R7: output valid right after the accepting edge, drops when drained.
    @(negedge clk_i);
    in_valid_i = 1'b1;
    opcode_i   = 8'd188;
    operand_i  = 32'h0000_00FF;
    check("R7 ready", {31'd0, in_ready_o}, 32'd1);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check("R7 valid", {31'd0, out_valid_o}, 32'd1);
    check("R7 result", result_o, 32'd8);
    @(negedge clk_i);
    check("R7 drained", {31'd0, out_valid_o}, 32'd0);
  endtask

  task automatic t_stall;
    @(negedge clk_i);
    out_ready_i = 1'b0;
    in_valid_i  = 1'b1;
    opcode_i    = 8'd189;
    operand_i   = 32'h0000_0100;
    @(negedge clk_i);
    check("R8 result A", result_o, 32'd8);
    check("R8 ready low", {31'd0, in_ready_o}, 32'd0);
    opcode_i  = 8'd191;
    operand_i = 32'h0040_0000;
    @(negedge clk_i);
    check("R8 hold valid", {31'd0, out_valid_o}, 32'd1);
    check("R8 hold result", result_o, 32'd8);
    out_ready_i = 1'b1;
    #1;
    check("R8 ready on drain", {31'd0, in_ready_o}, 32'd1);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check("R8 result B", result_o, 32'd22);
    check("R8 valid B", {31'd0, out_valid_o}, 32'd1);
  endtask

  task automatic t_random;
    logic [31:0] lfsr = 32'hACE1_2345;
    logic [7:0] op;
    for (int n = 0; n < 200; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      op = 8'd187 + 8'(n % 5);
      case (n % 7)
        0: run_op("R1-R5 rand", op, lfsr);
        1: run_op("R1-R5 rand", op, lfsr >> (n % 32));
        2: run_op("R1-R5 rand", op, ~(lfsr >> (n % 32)));
        default: run_op("R1-R5 rand", op, lfsr & (lfsr << 3));
      endcase
    end
  endtask

  initial begin
    #200_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #12;
    t_reset;
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_reverse;
    t_count;
    t_low;
    t_uhi;
    t_shi;
    t_bad_code;
    t_timing;
    t_stall;
    t_random;
    repeat (2) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule